// File: doc/BRIEF.md
# Dual-Set Dual-Modulus Synthesizer Divider

This block holds the programmable dividers of a frequency synthesizer. The VCO-side divider counts VCO cycles through a ÷16/÷17 prescaler. The prescaler is modelled in logic and steered by a swallow counter and a main (P) counter. The reference-side divider counts reference cycles. Each divider emits a single-cycle pulse once per full period, and a phase detector compares those two pulse trains. Both sources arrive as one-cycle tick strobes in the block's clock domain.

Two complete programmable sets are stored. Each set holds a VCO divide value, a reference divide value and a charge-pump current code. A select register bit chooses the set in use. An override pin pair can take the choice away from the register. A new selection or a newly written value does not cut a divider period short. Each divider adopts it at its own next period boundary. The current code follows once both dividers run from the same set.

Top module: `synth_dual_div`

## Requirements
- R1: After reset the select bit is 1, set 1 is in use by both dividers, both pulse outputs are low and `cp_code` equals the set-1 default code (0 with default parameters).
- R2: The VCO divider period is M = 16·P + A VCO ticks. P is bits [13:4] of the written M and A is bits [3:0]. The prescaler divides by 17 for the first A prescaler cycles of each period and by 16 for the rest. This holds for A = 0, A = 15 and M = 16383.
- R3: The reference divider period is R reference ticks.
- R4: Each divider output is a one-cycle pulse, raised in the cycle after the tick that ends a period. Only ticks are counted, so idle cycles between ticks do not change the period.
- R5: A written M below 256 is stored as 256, and a written R below 2 is stored as 2.
- R6: With the select value 1 the dividers use M1/R1 and `cp_code` shows CP1. With the value 0 they use M2/R2 and CP2. The write strobe's `wr_set` uses the same encoding.
- R7: While `ovr_en` is 1, `ovr_val` picks the set and the register bit is ignored. With `ovr_en` at 0 the register bit picks the set.
- R8: A new selection or a new divide value takes effect at the next period boundary of each divider. A write that lands on the very edge of a reload is first used at the boundary after that.
- R9: `cp_code` changes only in the cycle after a divider pulse, and only when both dividers run from the same set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vco_tick | input | 1 | One VCO cycle to be counted |
| ref_tick | input | 1 | One reference cycle to be counted |
| wr_en | input | 1 | Write strobe for one divider set |
| wr_set | input | 1 | Set addressed by the write: 1 = set 1, 0 = set 2 |
| wr_m | input | 14 | VCO divide value M (P in [13:4], A in [3:0]) |
| wr_r | input | 11 | Reference divide value R |
| wr_cp | input | 2 | Charge-pump current code |
| sel_we | input | 1 | Write strobe for the select register bit |
| sel_din | input | 1 | New select register bit value |
| ovr_en | input | 1 | Select override driven (1) or released (0) |
| ovr_val | input | 1 | Select value while the override is driven |
| vco_pulse | output | 1 | One-cycle pulse per VCO divider period |
| ref_pulse | output | 1 | One-cycle pulse per reference divider period |
| cp_code | output | 2 | Current code of the set in use |

## Verification
A register write and a divider reload can fall on the same clock edge. The bench provokes this by counting ticks from an observed VCO pulse. It places the write of a new M exactly on the tick that ends the next period. It then measures the next two periods, which must still carry the old value, and the third, which must carry the new one. The bench also makes the two dividers switch sets at different moments by giving them very different periods. It then judges that the current code stays on the old set until the slower divider has also crossed its boundary.

// File: rtl/synth_div_pkg.sv
// Shared widths and the divider-set record used across the synthesizer
// divider. Assumes the VCO count splits into a swallow field (low bits)
// and a main counter field (high bits).
package synth_div_pkg;

    localparam int A_W      = 4;           // swallow field width
    localparam int P_W      = 10;          // main counter field width
    localparam int M_W      = A_W + P_W;   // full VCO divide value width
    localparam int R_W      = 11;          // reference divide value width
    localparam int CP_W     = 2;           // charge-pump current code width
    localparam int NUM_SETS = 2;           // programmable sets, index = select value

    typedef struct packed {
        logic [M_W-1:0]  m;
        logic [R_W-1:0]  r;
        logic [CP_W-1:0] cp;
    } div_set_t;

endpackage

// File: rtl/sdd_cfg_bank.sv
// Storage for the two programmable divider sets and the select bit.
// Clamps written divide values to their lower limits (the upper limits
// equal the field maxima). Entry index equals the select value: entry 1
// is set 1, entry 0 is set 2. Resolves the select override.
module sdd_cfg_bank
    import synth_div_pkg::*;
#(
    parameter int DEF_M1  = 300,
    parameter int DEF_R1  = 400,
    parameter int DEF_CP1 = 0,
    parameter int DEF_M2  = 260,
    parameter int DEF_R2  = 50,
    parameter int DEF_CP2 = 3,
    parameter int M_MIN   = 256,
    parameter int R_MIN   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_set,
    input  logic [M_W-1:0]  wr_m,
    input  logic [R_W-1:0]  wr_r,
    input  logic [CP_W-1:0] wr_cp,
    input  logic            sel_we,
    input  logic            sel_din,
    input  logic            ovr_en,
    input  logic            ovr_val,
    output div_set_t        set_hi_o,
    output div_set_t        set_lo_o,
    output logic            req_sel_o
);

    localparam logic [M_W-1:0] M_FLOOR = M_W'(M_MIN);
    localparam logic [R_W-1:0] R_FLOOR = R_W'(R_MIN);
    localparam div_set_t SET1_RST = '{m: M_W'(DEF_M1), r: R_W'(DEF_R1), cp: CP_W'(DEF_CP1)};
    localparam div_set_t SET2_RST = '{m: M_W'(DEF_M2), r: R_W'(DEF_R2), cp: CP_W'(DEF_CP2)};

    div_set_t wr_clamped;
    div_set_t bank_q [NUM_SETS];
    logic     sel_q;

    // Raise out-of-range written values to the nearest legal limit.
    always_comb begin
        wr_clamped.m  = (wr_m < M_FLOOR) ? M_FLOOR : wr_m;
        wr_clamped.r  = (wr_r < R_FLOOR) ? R_FLOOR : wr_r;
        wr_clamped.cp = wr_cp;
    end

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        localparam logic     SEL_CODE = 1'(g);
        localparam div_set_t RST_VAL  = (g == 1) ? SET1_RST : SET2_RST;

        // Hold one set; load it when the write addresses this entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= RST_VAL;
            end else if (wr_en && (wr_set == SEL_CODE)) begin
                bank_q[g] <= wr_clamped;
            end
        end
    end

    // Select register bit, powering up on set 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b1;
        end else if (sel_we) begin
            sel_q <= sel_din;
        end
    end

    // A driven override pin wins over the register bit.
    always_comb begin
        req_sel_o = ovr_en ? ovr_val : sel_q;
        set_hi_o  = bank_q[1];
        set_lo_o  = bank_q[0];
    end

endmodule

// File: rtl/sdd_prescaler.sv
// Dual-modulus prescaler modelled in logic: counts VCO ticks and flags
// the tick that completes one prescaler cycle of 2**A_W ticks, or one
// more when div_hi is set. Assumes div_hi is steady within a cycle.
module sdd_prescaler
    import synth_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic div_hi,
    output logic wrap_o
);

    localparam int PRE_DIV = 2 ** A_W;
    localparam int PRE_W   = A_W + 1;
    localparam logic [PRE_W-1:0] LAST_LO = PRE_W'(PRE_DIV - 1);
    localparam logic [PRE_W-1:0] LAST_HI = PRE_W'(PRE_DIV);
    localparam logic [PRE_W-1:0] ONE     = PRE_W'(1);

    logic [PRE_W-1:0] cnt_q;

    // Flag the last tick of the current prescaler cycle.
    always_comb begin
        wrap_o = tick && (cnt_q == (div_hi ? LAST_HI : LAST_LO));
    end

    // Advance on each tick, restarting after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= wrap_o ? '0 : cnt_q + ONE;
        end
    end

endmodule

// File: rtl/sdd_m_div.sv
// VCO-side divider: a swallow counter holds the prescaler at the higher
// modulus for the first A prescaler cycles, and a P counter ends the
// period after P prescaler cycles, giving 16*P + A ticks. New values and
// the set choice load only at the period boundary. Assumes P >= 16.
module sdd_m_div
    import synth_div_pkg::*;
#(
    parameter int   RST_M   = 300,
    parameter logic RST_SEL = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [M_W-1:0] ld_m,
    input  logic           ld_sel,
    output logic           pulse_o,
    output logic           set_o
);

    localparam logic [M_W-1:0] RST_MV = M_W'(RST_M);
    localparam logic [P_W-1:0] P_ONE  = P_W'(1);
    localparam logic [A_W-1:0] A_ONE  = A_W'(1);

    logic [A_W-1:0] swal_q;
    logic [P_W-1:0] p_cnt_q;
    logic [P_W-1:0] p_lim_q;
    logic           set_q;
    logic           pulse_q;
    logic           swallowing;
    logic           pre_wrap;
    logic           period_end;

    // Higher modulus while swallow cycles remain; period ends on last P cycle.
    always_comb begin
        swallowing = |swal_q;
        period_end = pre_wrap && (p_cnt_q == (p_lim_q - P_ONE));
    end

    sdd_prescaler u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .div_hi (swallowing),
        .wrap_o (pre_wrap)
    );

    // Count prescaler cycles; reload limits and set at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_cnt_q <= '0;
            p_lim_q <= RST_MV[M_W-1:A_W];
            swal_q  <= RST_MV[A_W-1:0];
            set_q   <= RST_SEL;
        end else if (period_end) begin
            p_cnt_q <= '0;
            p_lim_q <= ld_m[M_W-1:A_W];
            swal_q  <= ld_m[A_W-1:0];
            set_q   <= ld_sel;
        end else if (pre_wrap) begin
            p_cnt_q <= p_cnt_q + P_ONE;
            if (swallowing) begin
                swal_q <= swal_q - A_ONE;
            end
        end
    end

    // One-cycle output pulse after the closing tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= period_end;
        end
    end

    assign pulse_o = pulse_q;
    assign set_o   = set_q;

endmodule

// File: rtl/sdd_r_div.sv
// Reference-side divider: counts reference ticks and ends each period
// after R ticks. The limit and set choice reload at the boundary.
// Assumes R >= 2.
module sdd_r_div
    import synth_div_pkg::*;
#(
    parameter int   RST_R   = 400,
    parameter logic RST_SEL = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [R_W-1:0] ld_r,
    input  logic           ld_sel,
    output logic           pulse_o,
    output logic           set_o
);

    localparam logic [R_W-1:0] R_ONE = R_W'(1);

    logic [R_W-1:0] cnt_q;
    logic [R_W-1:0] lim_q;
    logic           set_q;
    logic           pulse_q;
    logic           period_end;

    // The tick that brings the count to R closes the period.
    always_comb begin
        period_end = tick && (cnt_q == (lim_q - R_ONE));
    end

    // Count ticks; reload limit and set at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= R_W'(RST_R);
            set_q <= RST_SEL;
        end else if (period_end) begin
            cnt_q <= '0;
            lim_q <= ld_r;
            set_q <= ld_sel;
        end else if (tick) begin
            cnt_q <= cnt_q + R_ONE;
        end
    end

    // One-cycle output pulse after the closing tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= period_end;
        end
    end

    assign pulse_o = pulse_q;
    assign set_o   = set_q;

endmodule

// File: rtl/synth_dual_div.sv
// Top of the dual-set synthesizer divider. Routes the requested set to
// both dividers, which adopt it at their own period boundaries, and
// drives the current code once both run from the same set. Assumes both
// tick inputs are single-cycle strobes synchronous to clk.
module synth_dual_div
    import synth_div_pkg::*;
#(
    parameter int DEF_M1  = 300,
    parameter int DEF_R1  = 400,
    parameter int DEF_CP1 = 0,
    parameter int DEF_M2  = 260,
    parameter int DEF_R2  = 50,
    parameter int DEF_CP2 = 3,
    parameter int M_MIN   = 256,
    parameter int R_MIN   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vco_tick,
    input  logic            ref_tick,
    input  logic            wr_en,
    input  logic            wr_set,
    input  logic [M_W-1:0]  wr_m,
    input  logic [R_W-1:0]  wr_r,
    input  logic [CP_W-1:0] wr_cp,
    input  logic            sel_we,
    input  logic            sel_din,
    input  logic            ovr_en,
    input  logic            ovr_val,
    output logic            vco_pulse,
    output logic            ref_pulse,
    output logic [CP_W-1:0] cp_code
);

    div_set_t        set_hi;
    div_set_t        set_lo;
    div_set_t        next_set;
    logic            req_sel;
    logic            m_set;
    logic            r_set;
    logic [CP_W-1:0] cp_q;

    sdd_cfg_bank #(
        .DEF_M1 (DEF_M1),  .DEF_R1 (DEF_R1),  .DEF_CP1 (DEF_CP1),
        .DEF_M2 (DEF_M2),  .DEF_R2 (DEF_R2),  .DEF_CP2 (DEF_CP2),
        .M_MIN  (M_MIN),   .R_MIN  (R_MIN)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_set    (wr_set),
        .wr_m      (wr_m),
        .wr_r      (wr_r),
        .wr_cp     (wr_cp),
        .sel_we    (sel_we),
        .sel_din   (sel_din),
        .ovr_en    (ovr_en),
        .ovr_val   (ovr_val),
        .set_hi_o  (set_hi),
        .set_lo_o  (set_lo),
        .req_sel_o (req_sel)
    );

    // Values the dividers pick up at their next boundary.
    always_comb begin
        next_set = req_sel ? set_hi : set_lo;
    end

    sdd_m_div #(
        .RST_M   (DEF_M1),
        .RST_SEL (1'b1)
    ) u_mdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (vco_tick),
        .ld_m    (next_set.m),
        .ld_sel  (req_sel),
        .pulse_o (vco_pulse),
        .set_o   (m_set)
    );

    sdd_r_div #(
        .RST_R   (DEF_R1),
        .RST_SEL (1'b1)
    ) u_rdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (ref_tick),
        .ld_r    (next_set.r),
        .ld_sel  (req_sel),
        .pulse_o (ref_pulse),
        .set_o   (r_set)
    );

    // Refresh the current code after a pulse once both dividers agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cp_q <= CP_W'(DEF_CP1);
        end else if ((vco_pulse || ref_pulse) && (m_set == r_set)) begin
            cp_q <= m_set ? set_hi.cp : set_lo.cp;
        end
    end

    assign cp_code = cp_q;

endmodule

// File: rtl/sdd_checker.sv
// Property checker for the dual-set divider, bound to its top module.
// Observes output pulses, the set each divider runs from and the stored
// divide values.
module sdd_checker
    import synth_div_pkg::*;
#(
    parameter int M_MIN = 256,
    parameter int R_MIN = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            vco_pulse,
    input logic            ref_pulse,
    input logic [CP_W-1:0] cp_code,
    input logic            m_set,
    input logic            r_set,
    input logic [M_W-1:0]  set_hi_m,
    input logic [M_W-1:0]  set_lo_m,
    input logic [R_W-1:0]  set_hi_r,
    input logic [R_W-1:0]  set_lo_r
);

    a_r4_vco_single: assert property (@(posedge clk) disable iff (!rst_n)
        vco_pulse |=> !vco_pulse);

    a_r4_ref_single: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    a_r8_mset_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(m_set) |-> vco_pulse);

    a_r8_rset_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_set) |-> ref_pulse);

    a_r9_cp_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cp_code) |-> $past(vco_pulse || ref_pulse));

    a_r5_stored_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hi_m >= M_W'(M_MIN)) && (set_lo_m >= M_W'(M_MIN)) &&
        (set_hi_r >= R_W'(R_MIN)) && (set_lo_r >= R_W'(R_MIN)));

endmodule

bind synth_dual_div sdd_checker #(.M_MIN(M_MIN), .R_MIN(R_MIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vco_pulse (vco_pulse),
    .ref_pulse (ref_pulse),
    .cp_code   (cp_code),
    .m_set     (m_set),
    .r_set     (r_set),
    .set_hi_m  (set_hi.m),
    .set_lo_m  (set_lo.m),
    .set_hi_r  (set_hi.r),
    .set_lo_r  (set_lo.r)
);

// File: tb/synth_dual_div_tb_top.sv
`timescale 1ns/1ps
module synth_dual_div_tb_top;
    import synth_div_pkg::*;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            vco_tick = 1'b1;
    logic            ref_tick = 1'b1;
    logic            wr_en = 1'b0;
    logic            wr_set = 1'b0;
    logic [M_W-1:0]  wr_m = '0;
    logic [R_W-1:0]  wr_r = '0;
    logic [CP_W-1:0] wr_cp = '0;
    logic            sel_we = 1'b0;
    logic            sel_din = 1'b0;
    logic            ovr_en = 1'b0;
    logic            ovr_val = 1'b0;
    logic            vco_pulse;
    logic            ref_pulse;
    logic [CP_W-1:0] cp_code;

    int checks = 0;
    int failures = 0;
    logic gap_mode = 1'b0;

    // Measured periods in ticks, and double-pulse detection.
    int   m_cnt = 0, r_cnt = 0, m_meas = 0, r_meas = 0;
    logic m_prev = 1'b0, r_prev = 1'b0, dbl = 1'b0;

    always #10 clk = ~clk;

    synth_dual_div dut_i (
        .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .ref_tick(ref_tick),
        .wr_en(wr_en), .wr_set(wr_set), .wr_m(wr_m), .wr_r(wr_r), .wr_cp(wr_cp),
        .sel_we(sel_we), .sel_din(sel_din), .ovr_en(ovr_en), .ovr_val(ovr_val),
        .vco_pulse(vco_pulse), .ref_pulse(ref_pulse), .cp_code(cp_code)
    );

    // VCO tick source: continuous, or every other cycle in gap mode.
    always @(negedge clk) vco_tick <= gap_mode ? ~vco_tick : 1'b1;

    // Period monitor counting ticks between pulses.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; r_cnt <= 0; m_prev <= 1'b0; r_prev <= 1'b0;
        end else begin
            m_prev <= vco_pulse;
            r_prev <= ref_pulse;
            if ((vco_pulse && m_prev) || (ref_pulse && r_prev)) dbl <= 1'b1;
            if (vco_pulse) begin
                m_meas <= m_cnt;
                m_cnt  <= vco_tick ? 1 : 0;
            end else if (vco_tick) m_cnt <= m_cnt + 1;
            if (ref_pulse) begin
                r_meas <= r_cnt;
                r_cnt  <= ref_tick ? 1 : 0;
            end else if (ref_tick) r_cnt <= r_cnt + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic s, input int m, input int r, input int cp);
        wr_set = s; wr_m = M_W'(m); wr_r = R_W'(r); wr_cp = CP_W'(cp);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_sel(input logic v);
        sel_din = v; sel_we = 1'b1;
        @(negedge clk);
        sel_we = 1'b0;
    endtask

    // Returns one cycle after a VCO pulse, once the monitor has updated.
    task automatic wait_m();
        do @(negedge clk); while (!vco_pulse);
        @(negedge clk);
    endtask

    task automatic wait_r();
        do @(negedge clk); while (!ref_pulse);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 vco_pulse low", int'(vco_pulse), 0);
        chk("R1 ref_pulse low", int'(ref_pulse), 0);
        chk("R1 cp_code default", int'(cp_code), 0);
    endtask

    task automatic t_defaults();
        wait_m(); chk("R2 R6 default M1 period", m_meas, 300);
        wait_r(); chk("R3 R6 default R1 period", r_meas, 400);
    endtask

    task automatic t_new_m();
        do_write(1'b1, 325, 400, 0);
        wait_m(); chk("R8 period in progress keeps old M", m_meas, 300);
        wait_m(); chk("R2 R8 new M 325 (P=20 A=5)", m_meas, 325);
    endtask

    task automatic t_m_value(input int m);
        do_write(1'b1, m, 400, 0);
        wait_m();
        wait_m(); chk("R2 M pattern", m_meas, m);
    endtask

    task automatic t_gaps();
        gap_mode = 1'b1;
        wait_m();
        wait_m(); chk("R4 period counts ticks only", m_meas, 325);
        gap_mode = 1'b0;
        @(negedge clk);
        chk("R4 no double-cycle pulse", int'(dbl), 0);
    endtask

    task automatic t_coincide();
        wait_m();
        repeat (325 - 2) @(negedge clk);
        do_write(1'b1, 290, 400, 0);
        chk("R8 write lands on reload edge", int'(vco_pulse), 1);
        @(negedge clk);
        chk("R8 period ending at the write", m_meas, 325);
        wait_m(); chk("R8 reload on write edge used old M", m_meas, 325);
        wait_m(); chk("R8 coinciding write used one period later", m_meas, 290);
    endtask

    task automatic t_clamp();
        do_write(1'b0, 100, 1, 3);
        do_sel(1'b0);
        wait_m();
        wait_m(); chk("R5 R6 M below floor runs 256", m_meas, 256);
        wait_r(); chk("R5 R6 R below floor runs 2", r_meas, 2);
        chk("R6 cp_code shows CP2", int'(cp_code), 3);
    endtask

    task automatic t_override();
        ovr_en = 1'b1; ovr_val = 1'b1;
        wait_m();
        wait_m(); chk("R7 override picks set 1 M", m_meas, 290);
        wait_r(); chk("R7 override picks set 1 R", r_meas, 400);
        chk("R7 override picks CP1", int'(cp_code), 0);
        ovr_en = 1'b0;
        wait_m();
        wait_m(); chk("R7 released override returns to register", m_meas, 256);
    endtask

    task automatic t_cp_hold();
        do_write(1'b1, 290, 400, 1);
        wait_m();
        do_sel(1'b1);
        repeat (6) @(negedge clk);
        chk("R9 cp held while dividers disagree", int'(cp_code), 3);
        wait_m();
        chk("R8 switching period still set 2", m_meas, 256);
        chk("R9 cp follows once both on set 1", int'(cp_code), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_defaults();
        t_new_m();
        t_m_value(272);
        t_m_value(271);
        t_m_value(16383);
        t_m_value(325);
        t_gaps();
        t_coincide();
        t_clamp();
        t_override();
        t_cp_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule